// File: doc/BRIEF.md
# Cacheable Write ECC Rule Monitor

This block sits beside an AXI write channel that runs from a programmable-logic master into a coherent host port. It observes the address-write (AW) and write-data (W) handshakes but never drives them. It tracks every burst beat by beat. For each cacheable write it decides whether the burst would leave a 64-bit ECC granule of the host cache partly written. A partly written granule turns into an uncorrectable double-bit error. The monitor also flags bursts that do not start on a 32-byte cache line, which cost performance but do no harm.

Address attributes are queued in arrival order, so each data beat is judged against its own burst. The strobe rule depends on the master data width, set by a parameter to 32, 64 or 128 bits, and the monitor judges it over the whole burst. When a burst closes, the monitor emits one pulse with a reason code. A sticky register keeps every reason seen until software-side logic clears it through a synchronous input.

Top module: `cacheWriteMonitor`

## Requirements
- R1: A burst is cacheable when bit 1 of `awCache` is set. Non-cacheable bursts still use up their W beats, but they never cause a pulse or set a sticky bit.
- R2: A cacheable burst whose `awAddr[2:0]` is not zero is reported with reason code 3'd1.
- R3: With `DATA_W` = 32, a cacheable burst whose beat count (`awLen`+1) is not 2, 4, 8 or 16 is reported with code 3'd2. With 64 or 128 there is no length rule.
- R4: Strobe rule, code 3'd3 if any beat of a cacheable burst breaks it. With 32 or 64, all byte strobes must be set. With 128, byte lanes 7..0 must be all set, or byte lanes 15..8 must be all set, or both.
- R5: A cacheable burst whose `awAddr[4:0]` is not zero raises warning code 3'd4. This warning is recorded as well as code 3'd1 when both apply.
- R6: A burst closes at its (`awLen`+1)-th beat or at the first beat with `wLast`, whichever comes first. If those two points differ, the burst gets code 3'd5.
- R7: A burst that has at least one reason gives exactly one `violPulse`, in the cycle after its closing beat handshake. `violCode` carries the highest-priority reason in the order 1, 2, 3, 5, 4. `violCode` is 0 whenever there is no pulse.
- R8: `violSticky` bit k-1 sets for every reason k found in a reported burst, not only the reason that was encoded. Bits hold until `stickyClr`. A clear in the same cycle as a new report leaves only the new bits.
- R9: Up to `QUEUE_DEPTH` AW entries wait in order, and W beats are matched to the oldest one. An AW accepted in the same cycle as the first beat is used directly. W beats that arrive with no AW outstanding are ignored.
- R10: After reset, `violPulse`, `violCode` and `violSticky` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| stickyClr | input | 1 | Synchronous clear of the sticky reasons |
| awValid | input | 1 | Observed AW valid |
| awReady | input | 1 | Observed AW ready |
| awAddr | input | ADDR_W | Observed AW address |
| awLen | input | 8 | Observed AW burst length minus one |
| awCache | input | 4 | Observed AW cache attributes |
| wValid | input | 1 | Observed W valid |
| wReady | input | 1 | Observed W ready |
| wStrb | input | DATA_W/8 | Observed W byte strobes |
| wLast | input | 1 | Observed W last flag |
| violPulse | output | 1 | One-cycle report of a flagged burst |
| violCode | output | 3 | Highest-priority reason of the report |
| violSticky | output | 5 | Accumulated reasons, bit k-1 for code k |

## Verification
The hardest cases to reach are those where AW and W go out of step. One is an address that arrives in the same cycle as its first data beat and must take the bypass path. Another is a burst that closes early on `wLast`, so the following beats have to land on the next queued entry. The bench builds both from scheduled handshakes: address phases queued ahead of the data, a shared AW and W cycle, orphan beats, and early and missing `wLast`. After each of these it sends a clean follow-up burst, to show that the queue is still aligned. A second instance at 128-bit width receives the same traffic, so the per-half strobe rule and the absence of a length rule can be seen side by side.

// File: rtl/cwmPkg.sv
package cwmPkg;
  localparam int LEN_W    = 8;
  localparam int REASON_N = 5;

  typedef enum logic [2:0] {
    RSN_NONE = 3'd0,
    RSN_ADDR = 3'd1,
    RSN_LEN  = 3'd2,
    RSN_STRB = 3'd3,
    RSN_LINE = 3'd4,
    RSN_LAST = 3'd5
  } reason_e;

  typedef struct packed {
    logic             cacheable;
    logic [4:0]       addrLow;
    logic [LEN_W-1:0] len;
  } awAttr_t;

  typedef struct packed {
    logic push;
    logic beat;
    logic burstEnd;
    logic lastMismatch;
  } ctrlStb_t;
endpackage

// File: rtl/cwmControl.sv
module cwmControl import cwmPkg::*; #(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             awFire,
  input  logic             wFire,
  input  logic             wLast,
  input  logic [LEN_W-1:0] headLen,
  output ctrlStb_t         ctrl,
  output logic             queueEmpty,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [CNT_W-1:0] occupancy
);
  logic [LEN_W-1:0] beatCnt;
  logic             headValid;
  logic             lenHit;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign queueEmpty = (occupancy == '0);
  assign headValid  = !queueEmpty || awFire;
  assign lenHit     = (beatCnt == headLen);

  always_comb begin
    ctrl.beat         = wFire && headValid;
    ctrl.burstEnd     = ctrl.beat && (wLast || lenHit);
    ctrl.lastMismatch = ctrl.burstEnd && (wLast != lenHit);
    ctrl.push         = awFire && ((occupancy != CNT_W'(DEPTH)) || ctrl.burstEnd);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      occupancy <= '0;
      beatCnt   <= '0;
    end else begin
      if (ctrl.push)     wrPtr <= bump(wrPtr);
      if (ctrl.burstEnd) rdPtr <= bump(rdPtr);
      unique case ({ctrl.push, ctrl.burstEnd})
        2'b10:   occupancy <= occupancy + 1'b1;
        2'b01:   occupancy <= occupancy - 1'b1;
        default: occupancy <= occupancy;
      endcase
      if (ctrl.burstEnd)  beatCnt <= '0;
      else if (ctrl.beat) beatCnt <= beatCnt + 1'b1;
    end
  end
endmodule

// File: rtl/cwmDatapath.sv
module cwmDatapath import cwmPkg::*; #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4,
  localparam int STRB_W = DATA_W / 8,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                stickyClr,
  input  ctrlStb_t            ctrl,
  input  logic                queueEmpty,
  input  logic [PTR_W-1:0]    wrPtr,
  input  logic [PTR_W-1:0]    rdPtr,
  input  awAttr_t             awIn,
  input  logic [STRB_W-1:0]   wStrb,
  output logic [LEN_W-1:0]    headLen,
  output logic                violPulse,
  output logic [2:0]          violCode,
  output logic [REASON_N-1:0] violSticky
);
  awAttr_t             queueMem [DEPTH];
  awAttr_t             head;
  logic                beatStrbBad;
  logic                lenBad;
  logic                strbAcc;
  logic [REASON_N-1:0] reasons;
  logic [REASON_N-1:0] found;

  always_ff @(posedge clk) begin
    if (ctrl.push) queueMem[wrPtr] <= awIn;
  end

  assign head    = queueEmpty ? awIn : queueMem[rdPtr];
  assign headLen = head.len;

  generate
    if (DATA_W == 128) begin : g_halfRule
      assign beatStrbBad = !((&wStrb[7:0]) || (&wStrb[15:8]));
    end else begin : g_fullRule
      assign beatStrbBad = !(&wStrb);
    end

    if (DATA_W == 32) begin : g_lenRule
      assign lenBad = !((head.len == LEN_W'(1)) || (head.len == LEN_W'(3)) ||
                        (head.len == LEN_W'(7)) || (head.len == LEN_W'(15)));
    end else begin : g_noLenRule
      assign lenBad = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)              strbAcc <= 1'b0;
    else if (ctrl.burstEnd) strbAcc <= 1'b0;
    else if (ctrl.beat)     strbAcc <= strbAcc | beatStrbBad;
  end

  always_comb begin
    reasons[0] = (head.addrLow[2:0] != 3'd0);
    reasons[1] = lenBad;
    reasons[2] = strbAcc | beatStrbBad;
    reasons[3] = (head.addrLow != 5'd0);
    reasons[4] = ctrl.lastMismatch;
    found      = (ctrl.burstEnd && head.cacheable) ? reasons : '0;
  end

  function automatic logic [2:0] pickCode(input logic [REASON_N-1:0] r);
    if (r[0]) return RSN_ADDR;
    if (r[1]) return RSN_LEN;
    if (r[2]) return RSN_STRB;
    if (r[4]) return RSN_LAST;
    if (r[3]) return RSN_LINE;
    return RSN_NONE;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      violPulse  <= 1'b0;
      violCode   <= RSN_NONE;
      violSticky <= '0;
    end else begin
      violPulse  <= |found;
      violCode   <= pickCode(found);
      violSticky <= (stickyClr ? '0 : violSticky) | found;
    end
  end
endmodule

// File: rtl/cacheWriteMonitor.sv
module cacheWriteMonitor import cwmPkg::*; #(
  parameter int DATA_W      = 64,
  parameter int ADDR_W      = 32,
  parameter int QUEUE_DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  stickyClr,
  input  logic                  awValid,
  input  logic                  awReady,
  input  logic [ADDR_W-1:0]     awAddr,
  input  logic [LEN_W-1:0]      awLen,
  input  logic [3:0]            awCache,
  input  logic                  wValid,
  input  logic                  wReady,
  input  logic [DATA_W/8-1:0]   wStrb,
  input  logic                  wLast,
  output logic                  violPulse,
  output logic [2:0]            violCode,
  output logic [REASON_N-1:0]   violSticky
);
  localparam int PTR_W = (QUEUE_DEPTH > 1) ? $clog2(QUEUE_DEPTH) : 1;
  localparam int CNT_W = $clog2(QUEUE_DEPTH + 1);

  ctrlStb_t         ctrl;
  awAttr_t          awIn;
  logic             queueEmpty;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] queueOcc;
  logic [LEN_W-1:0] headLen;
  logic             unusedBits;

  assign awIn.cacheable = awCache[1];
  assign awIn.addrLow   = awAddr[4:0];
  assign awIn.len       = awLen;
  assign unusedBits     = ^{awAddr[ADDR_W-1:5], awCache[3:2], awCache[0]};

  cwmControl #(.DEPTH(QUEUE_DEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .awFire    (awValid && awReady),
    .wFire     (wValid && wReady),
    .wLast     (wLast),
    .headLen   (headLen),
    .ctrl      (ctrl),
    .queueEmpty(queueEmpty),
    .wrPtr     (wrPtr),
    .rdPtr     (rdPtr),
    .occupancy (queueOcc)
  );

  cwmDatapath #(.DATA_W(DATA_W), .DEPTH(QUEUE_DEPTH)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .stickyClr (stickyClr),
    .ctrl      (ctrl),
    .queueEmpty(queueEmpty),
    .wrPtr     (wrPtr),
    .rdPtr     (rdPtr),
    .awIn      (awIn),
    .wStrb     (wStrb),
    .headLen   (headLen),
    .violPulse (violPulse),
    .violCode  (violCode),
    .violSticky(violSticky)
  );
endmodule

// File: rtl/cwmChecker.sv
module cwmChecker #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             stickyClr,
  input logic             awValid,
  input logic             awReady,
  input logic             wValid,
  input logic             wReady,
  input logic             violPulse,
  input logic [2:0]       violCode,
  input logic [4:0]       violSticky,
  input logic [CNT_W-1:0] occupancy
);
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    violPulse |-> (violCode >= 3'd1 && violCode <= 3'd5)); // R7
  AST_CODE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !violPulse |-> (violCode == 3'd0)); // R7
  AST_PULSE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    violPulse |-> $past(wValid && wReady)); // R7
  AST_STICKY_HAS_CODE: assert property (@(posedge clk) disable iff (!rstN)
    violPulse |-> violSticky[violCode - 3'd1]); // R8
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stickyClr |=> ((violSticky & $past(violSticky)) == $past(violSticky))); // R8
  AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    stickyClr |=> (violSticky == 5'd0 || violPulse)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (awValid && awReady) |-> (occupancy != CNT_W'(DEPTH) || (wValid && wReady))); // R9
endmodule

bind cacheWriteMonitor cwmChecker #(.DEPTH(QUEUE_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .stickyClr (stickyClr),
  .awValid   (awValid),
  .awReady   (awReady),
  .wValid    (wValid),
  .wReady    (wReady),
  .violPulse (violPulse),
  .violCode  (violCode),
  .violSticky(violSticky),
  .occupancy (queueOcc)
);

// File: tb/tb_cacheWriteMonitor.sv
`timescale 1ns/1ps
module tb_cacheWriteMonitor;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stickyClr = 1'b0;
  logic        awValid = 1'b0;
  logic        awReady = 1'b1;
  logic [31:0] awAddr = '0;
  logic [7:0]  awLen = '0;
  logic [3:0]  awCache = '0;
  logic        wValid = 1'b0;
  logic        wReady = 1'b1;
  logic [3:0]  wStrb = '0;
  logic [15:0] wStrbWide = '0;
  logic        wLast = 1'b0;
  logic        violPulse, violPulseWide;
  logic [2:0]  violCode, violCodeWide;
  logic [4:0]  violSticky, violStickyWide;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cacheWriteMonitor #(.DATA_W(32)) dut (
    .clk(clk), .rstN(rstN), .stickyClr(stickyClr),
    .awValid(awValid), .awReady(awReady), .awAddr(awAddr), .awLen(awLen), .awCache(awCache),
    .wValid(wValid), .wReady(wReady), .wStrb(wStrb), .wLast(wLast),
    .violPulse(violPulse), .violCode(violCode), .violSticky(violSticky));

  cacheWriteMonitor #(.DATA_W(128)) dutWide (
    .clk(clk), .rstN(rstN), .stickyClr(stickyClr),
    .awValid(awValid), .awReady(awReady), .awAddr(awAddr), .awLen(awLen), .awCache(awCache),
    .wValid(wValid), .wReady(wReady), .wStrb(wStrbWide), .wLast(wLast),
    .violPulse(violPulseWide), .violCode(violCodeWide), .violSticky(violStickyWide));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  task automatic clearSticky();
    stickyClr = 1'b1;
    @(negedge clk);
    stickyClr = 1'b0;
  endtask

  task automatic sendAw(input logic [31:0] addr, input int len, input bit cache);
    awValid = 1'b1; awAddr = addr; awLen = 8'(len); awCache = cache ? 4'b0010 : 4'b0000;
    @(negedge clk);
    awValid = 1'b0;
  endtask

  task automatic sendBeats(input int n, input int badBeat, input logic [3:0] badStrb,
                           input logic [15:0] wideBad, input int lastBeat, input bit clrLast);
    for (int i = 0; i < n; i++) begin
      wValid    = 1'b1;
      wStrb     = (i == badBeat) ? badStrb : 4'hF;
      wStrbWide = (i == badBeat) ? wideBad : 16'hFFFF;
      wLast     = (i == lastBeat);
      stickyClr = clrLast && (i == n - 1);
      @(negedge clk);
      awValid = 1'b0;
    end
    wValid = 1'b0; wLast = 1'b0; stickyClr = 1'b0;
  endtask

  task automatic runBurst(input logic [31:0] addr, input int len, input bit cache, input int n,
                          input int badBeat, input logic [3:0] badStrb, input logic [15:0] wideBad,
                          input int lastBeat, input bit together, input bit clrLast);
    if (together) begin
      awValid = 1'b1; awAddr = addr; awLen = 8'(len); awCache = cache ? 4'b0010 : 4'b0000;
    end else begin
      sendAw(addr, len, cache);
    end
    sendBeats(n, badBeat, badStrb, wideBad, lastBeat, clrLast);
  endtask

  task automatic testReset();
    chk("R10 pulse", violPulse, 0);
    chk("R10 code", violCode, 0);
    chk("R10 sticky", violSticky, 0);
  endtask

  task automatic testLegal();
    runBurst(32'h100, 3, 1, 4, -1, 4'hF, 16'hFFFF, 3, 0, 0);
    chk("R7 legal burst quiet", violPulse, 0);
    chk("R7 legal burst code", violCode, 0);
    chk("R4 legal wide quiet", violPulseWide, 0);
  endtask

  task automatic testNonCacheable();
    runBurst(32'h105, 2, 0, 3, 1, 4'h0, 16'h0000, -1, 0, 0);
    chk("R1 noncacheable pulse", violPulse, 0);
    chk("R1 noncacheable sticky", violSticky, 0);
    chk("R1 noncacheable wide sticky", violStickyWide, 0);
  endtask

  task automatic testMisalign();
    runBurst(32'h104, 3, 1, 4, -1, 4'hF, 16'hFFFF, 3, 0, 0);
    chk("R2 misaligned pulse", violPulse, 1);
    chk("R2 misaligned code", violCode, 1);
    chk("R5 misaligned sticky", violSticky, 5'b01001);
    clearSticky();
    chk("R8 cleared sticky", violSticky, 0);
  endtask

  task automatic testLength();
    runBurst(32'h200, 2, 1, 3, -1, 4'hF, 16'hFFFF, 2, 0, 0);
    chk("R3 three-beat code", violCode, 2);
    chk("R3 three-beat sticky", violSticky, 5'b00010);
    chk("R3 no length rule at 128", violPulseWide, 0);
    clearSticky();
  endtask

  task automatic testStrobe();
    runBurst(32'h300, 3, 1, 4, 2, 4'b0111, 16'hFFFF, 3, 0, 0);
    chk("R4 partial strobe code", violCode, 3);
    clearSticky();
    runBurst(32'h400, 3, 1, 4, 1, 4'hF, 16'h00FF, 3, 0, 0);
    chk("R4 wide lower half legal", violPulseWide, 0);
    runBurst(32'h400, 3, 1, 4, 2, 4'hF, 16'hFF00, 3, 0, 0);
    chk("R4 wide upper half legal", violPulseWide, 0);
    runBurst(32'h400, 3, 1, 4, 3, 4'hF, 16'h0FF0, 3, 0, 0);
    chk("R4 wide split strobe code", violCodeWide, 3);
    chk("R4 narrow full strobes quiet", violPulse, 0);
    clearSticky();
  endtask

  task automatic testLineWarn();
    runBurst(32'h208, 1, 1, 2, -1, 4'hF, 16'hFFFF, 1, 0, 0);
    chk("R5 line warning code", violCode, 4);
    chk("R5 line warning sticky", violSticky, 5'b01000);
    clearSticky();
  endtask

  task automatic testLast();
    runBurst(32'h300, 3, 1, 2, -1, 4'hF, 16'hFFFF, 1, 0, 0);
    chk("R6 early last code", violCode, 5);
    chk("R6 early last sticky", violSticky, 5'b10000);
    runBurst(32'h340, 1, 1, 2, -1, 4'hF, 16'hFFFF, 1, 0, 0);
    chk("R6 next burst after early close", violPulse, 0);
    runBurst(32'h300, 1, 1, 2, -1, 4'hF, 16'hFFFF, -1, 0, 0);
    chk("R6 missing last code", violCode, 5);
    clearSticky();
  endtask

  task automatic testPriority();
    runBurst(32'h104, 2, 1, 3, 0, 4'h0, 16'hFFFF, 2, 0, 0);
    chk("R7 priority code", violCode, 1);
    chk("R8 all reasons sticky", violSticky, 5'b01111);
    @(negedge clk);
    chk("R7 single pulse", violPulse, 0);
    clearSticky();
  endtask

  task automatic testQueue();
    sendAw(32'h500, 1, 1);
    sendAw(32'h508, 1, 1);
    sendBeats(2, -1, 4'hF, 16'hFFFF, 1, 0);
    chk("R9 first queued burst quiet", violPulse, 0);
    sendBeats(2, -1, 4'hF, 16'hFFFF, 1, 0);
    chk("R9 second queued burst code", violCode, 4);
    clearSticky();
    runBurst(32'h600, 1, 1, 2, 0, 4'h3, 16'hFFFF, 1, 1, 0);
    chk("R9 same-cycle AW bypass code", violCode, 3);
    clearSticky();
    sendBeats(1, 0, 4'h0, 16'h0000, 0, 0);
    chk("R9 orphan beat pulse", violPulse, 0);
    chk("R9 orphan beat sticky", violSticky, 0);
    runBurst(32'h700, 1, 1, 2, -1, 4'hF, 16'hFFFF, 1, 0, 0);
    chk("R9 aligned after orphan", violPulse, 0);
  endtask

  task automatic testClearRace();
    runBurst(32'h208, 1, 1, 2, -1, 4'hF, 16'hFFFF, 1, 0, 0);
    runBurst(32'h200, 2, 1, 3, -1, 4'hF, 16'hFFFF, 2, 0, 1);
    chk("R8 clear with new report", violSticky, 5'b00010);
    clearSticky();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLegal();
    testNonCacheable();
    testMisalign();
    testLength();
    testStrobe();
    testLineWarn();
    testLast();
    testPriority();
    testQueue();
    testClearRace();
    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule